// File: doc/BRIEF.md
# Oversampling SPI Slave

This block is a word-oriented serial slave that runs entirely from a fast internal clock. It does not clock any logic from the external serial clock. The serial clock, the active-low select and the receive data are each passed through a two-flop synchroniser. Their rising and falling edges are then detected in the internal clock domain. Because of this, the external serial clock period must be at least eight internal cycles.

The serial clock idles low. Receive data is sampled on each falling edge of the serial clock, most significant bit first. After `DATA_W` bits, the block presents the assembled word together with a one-cycle valid pulse. The transmit word is captured when the select is seen falling, and its most significant bit is driven at once. Each rising serial clock edge after the first moves the output to the next bit. The output enable follows the synchronised select, which makes the data output high-impedance whenever the slave is not selected.

A frame that ends early is dropped. The bit counter restarts whenever the select is high.

Top module: `spi_os_slave`

## Requirements
- R1: After reset, `miso_oe_o` is 0, `rx_valid_o` is 0 and `rx_word_o` is all zeros.
- R2: No more than 3 internal clock edges after `cs_ni` falls, `miso_oe_o` is 1 and `miso_o` equals bit `DATA_W-1` of `tx_word_i` as sampled at the select fall.
- R3: The master samples `miso_o` just before each falling edge of `sclk_i`. At the falling edge that ends bit k (k counted from 0), it sees bit `DATA_W-1-k` of the latched transmit word. The output therefore does not move on the first rising edge and moves one bit on each rising edge after it.
- R4: `mosi_i` is sampled on falling edges of `sclk_i`. The first bit sampled becomes bit `DATA_W-1` of `rx_word_o`. After the `DATA_W`-th falling edge, `rx_word_o` holds the word and `rx_valid_o` is high for exactly one cycle.
- R5: No more than 3 internal clock edges after `cs_ni` rises, `miso_oe_o` is 0.
- R6: A frame that ends with fewer than `DATA_W` falling edges produces no valid pulse. The next frame is received correctly from its first bit.
- R7: While `cs_ni` is high, activity on `sclk_i` and `mosi_i` produces no valid pulse and leaves `miso_oe_o` at 0.
- R8: Transfers are correct at the minimum serial clock period of 8 internal cycles, with 4 cycles high and 4 low.
- R9: Changes on `tx_word_i` after the select fall do not affect the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | External serial clock, idle low |
| cs_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial receive data |
| tx_word_i | input | DATA_W | Word to transmit, latched at select fall |
| miso_o | output | 1 | Serial transmit data |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| rx_word_o | output | DATA_W | Last complete received word |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_word_o` updates |

## Verification
The bench sweeps a set of receive and transmit words at the minimum half-period of 4 cycles and at 6 cycles. At every bit it checks the serial output, and at every frame end it checks the received word.
- If the first rising edge shifted the output, the master would see every transmitted bit one position early.
- If the bit counter did not restart when the select rose, the frame after a truncated one would come out misaligned, or would raise its valid pulse partway through.
- If the transmit word were read live instead of latched, changing `tx_word_i` partway through a frame would corrupt the serial output.
- If edges were accepted while deselected, toggling the clock with the select high would produce spurious words.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_IN      = 3;
  localparam int IDX_SCLK    = 0;
  localparam int IDX_CS      = 1;
  localparam int IDX_MOSI    = 2;
  // select idles high, everything else low
  localparam logic [NUM_IN-1:0] IN_RST_VAL = 3'b010;
endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{RST_VAL[g]}};
        prev_q  <= RST_VAL[g];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;

    // a detected edge cannot repeat in the next cycle
    edge_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_o[g] | fall_o[g]) |=> !(rise_o[g] | fall_o[g]));
  end
endmodule

// File: rtl/spi_os_shift.sv
module spi_os_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              cs_lvl_i,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  logic              mosi_lvl_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_word_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              first_q, oe_q, valid_q;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rx_sh_q[DATA_W-2:0], mosi_lvl_i};

  // transmit path: latch at select fall, hold on first rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
      first_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (cs_fall_i) begin
        tx_sh_q <= tx_word_i;
        first_q <= 1'b1;
        oe_q    <= 1'b1;
      end else if (cs_rise_i) begin
        oe_q    <= 1'b0;
        first_q <= 1'b0;
      end else if (sclk_rise_i && !cs_lvl_i) begin
        if (first_q) first_q <= 1'b0;
        else         tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  // receive path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q   <= '0;
      rx_word_q <= '0;
      bit_cnt_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (cs_lvl_i) begin
        bit_cnt_q <= '0;
      end else if (sclk_fall_i) begin
        rx_sh_q <= rx_next;
        if (bit_cnt_q == LAST_BIT) begin
          bit_cnt_q <= '0;
          rx_word_q <= rx_next;
          valid_q   <= 1'b1;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  assign miso_o     = tx_sh_q[DATA_W-1];
  assign miso_oe_o  = oe_q;
  assign rx_word_o  = rx_word_q;
  assign rx_valid_o = valid_q;

  // R2
  oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> miso_oe_o);
  // R2
  first_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (miso_o == $past(tx_word_i[DATA_W-1])));
  // R5
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !miso_oe_o);
  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R6
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_lvl_i |=> (bit_cnt_q == '0));
  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= LAST_BIT);
endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  import spi_os_pkg::*;

  logic [NUM_IN-1:0] in_raw, in_lvl, in_rise, in_fall;

  assign in_raw[IDX_SCLK] = sclk_i;
  assign in_raw[IDX_CS]   = cs_ni;
  assign in_raw[IDX_MOSI] = mosi_i;

  spi_os_sync #(
    .WIDTH  (NUM_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IN_RST_VAL)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(in_raw),
    .lvl_o  (in_lvl),
    .rise_o (in_rise),
    .fall_o (in_fall)
  );

  spi_os_shift #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_rise_i(in_rise[IDX_SCLK]),
    .sclk_fall_i(in_fall[IDX_SCLK]),
    .cs_lvl_i   (in_lvl[IDX_CS]),
    .cs_rise_i  (in_rise[IDX_CS]),
    .cs_fall_i  (in_fall[IDX_CS]),
    .mosi_lvl_i (in_lvl[IDX_MOSI]),
    .tx_word_i  (tx_word_i),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .rx_word_o  (rx_word_o),
    .rx_valid_o (rx_valid_o)
  );

  // R7
  no_idle_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_lvl[IDX_CS] && $past(in_lvl[IDX_CS])) |-> !rx_valid_o);
endmodule

// File: tb/spi_os_slave_tb.sv
module spi_os_slave_tb;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [DATA_W-1:0] tx_word = '0;
  logic miso, miso_oe, rx_valid;
  logic [DATA_W-1:0] rx_word;

  int checks = 0, failures = 0;
  int vcount = 0;
  logic [DATA_W-1:0] last_rx = '0;

  always #2 clk = ~clk;

  spi_os_slave #(.DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .tx_word_i(tx_word), .miso_o(miso), .miso_oe_o(miso_oe),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) if (rst_ni && rx_valid) begin
    vcount++;
    last_rx = rx_word;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits clock pulses; tx_alt is driven onto tx_word after select fall
  task automatic frame(input logic [DATA_W-1:0] txw, input logic [DATA_W-1:0] rxw,
                       input int nbits, input int half, input logic [DATA_W-1:0] tx_alt);
    tx_word = txw;
    cs_n = 1'b0;
    cyc(3);
    chk(miso_oe == 1'b1, "R2 oe", miso_oe, 1);
    chk(miso == txw[DATA_W-1], "R2 msb", miso, txw[DATA_W-1]);
    tx_word = tx_alt;
    cyc(2);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      mosi = rxw[DATA_W-1-i];
      cyc(half);
      chk(miso == txw[DATA_W-1-i], (half == 4) ? "R3 R8 R9 bit" : "R3 R9 bit",
          miso, txw[DATA_W-1-i]);
      sclk = 1'b0;
      cyc(half);
    end
    cs_n = 1'b1;
    cyc(3);
    chk(miso_oe == 1'b0, "R5 oe off", miso_oe, 0);
    cyc(2);
  endtask

  initial begin
    cyc(2);
    chk(miso_oe == 1'b0 && rx_valid == 1'b0 && rx_word == '0, "R1 reset",
        {miso_oe, rx_valid}, 0);
    rst_ni = 1'b1;
    cyc(3);

    // sweep words at two speeds
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 24; p++) begin
        logic [DATA_W-1:0] t, r;
        int v0;
        t = DATA_W'(p * 37 + 5 + s);
        r = DATA_W'(p * 91 + 170 - s * 3);
        if (p == 0) begin t = '1; r = '0; end
        if (p == 1) begin t = '0; r = '1; end
        v0 = vcount;
        frame(t, r, DATA_W, (s == 0) ? 4 : 6, ~t);
        chk(vcount == v0 + 1, "R4 one pulse", vcount - v0, 1);
        chk(last_rx == r, (s == 0) ? "R4 R8 word" : "R4 word", last_rx, r);
      end
    end

    // short frame followed by full frame
    begin
      int v0;
      v0 = vcount;
      frame(8'hC3, 8'hA5, 5, 4, 8'h00);
      chk(vcount == v0, "R6 short no pulse", vcount - v0, 0);
      frame(8'h5A, 8'h3C, DATA_W, 4, 8'hFF);
      chk(vcount == v0 + 1, "R6 recovery pulse", vcount - v0, 1);
      chk(last_rx == 8'h3C, "R6 recovery word", last_rx, 8'h3C);
    end

    // deselected activity is ignored
    begin
      int v0;
      v0 = vcount;
      for (int i = 0; i < 2 * DATA_W; i++) begin
        sclk = 1'b1; mosi = i[0];
        cyc(4);
        chk(miso_oe == 1'b0, "R7 oe idle", miso_oe, 0);
        sclk = 1'b0;
        cyc(4);
      end
      cyc(4);
      chk(vcount == v0, "R7 no pulse", vcount - v0, 0);
      chk(last_rx == 8'h3C, "R7 word kept", rx_word, 8'h3C);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule